// File: doc/BRIEF.md
# Repeating Command Queue Sequencer

This block is a small command FIFO that hands 32-bit conversion commands, one at a time, to a converter back end. A writer pushes commands into eight storage slots and the sequencer issues them in arrival order over a valid/ready handshake. Two flag bits inside each command steer the flow. One marks where a repeating section begins. The other halts issue after that command is accepted.

Once a repeat-marked command has executed, its slot and every slot after it stay protected. They count as occupied, so the writer cannot overwrite them. A halted sequencer waits for a repeat trigger. Without a pending advance, the trigger replays the protected section from its first entry. With an advance pending, the trigger drops the protection and lets issue continue past the halting command. The advance trigger may arrive at any time. It is latched and acted on only at the next repeat trigger, so a section can be replayed as often as the system needs before the queue moves on.

Top module: `rpt_cmd_seq`

## Requirements
- R1: After reset the write, read and repeat pointers are zero, the repeat pointer is invalid, the sequencer is not paused, `full` is low and `cmd_valid` is low.
- R2: `full` is high when eight slots are occupied, and a push while `full` is high is dropped: `wr_ptr` keeps its value and no stored command changes.
- R3: Commands are issued in push order. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds its value. The read pointer advances by one per accepted command.
- R4: When a command with bit 30 (the repeat flag) set is accepted, `rpt_ptr` takes that command's slot pointer and `rpt_valid` goes high.
- R5: While `rpt_valid` is high, every slot from `rpt_ptr` up to `wr_ptr` counts as occupied when `full` is computed, even slots already executed.
- R6: When a command with bit 31 (the pause flag) set is accepted, `paused` goes high, and no command is issued while paused.
- R7: A repeat trigger while paused with no advance pending clears `paused` and moves the read pointer to `rpt_ptr`, so the section from the repeat command through the pause command runs again.
- R8: A repeat trigger while paused with an advance pending, or with an advance pulse in the same cycle, clears `paused` and `rpt_valid` without moving the read pointer. The protected slots are released and issue resumes after the pause command.
- R9: An advance pulse is held as pending and has no effect on its own. Several pulses before one repeat trigger count as one, and the pending state is cleared when a repeat trigger consumes it.
- R10: A repeat trigger while not paused has no effect on the pointers or the pause state.
- R11: A repeat trigger while paused with `rpt_valid` low clears `paused`, and issue continues with the next stored command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Writer offers a command |
| push_data | input | CMD_W | Command word to store |
| full | output | 1 | No free slot; pushes are dropped |
| cmd_valid | output | 1 | A command is offered to the consumer |
| cmd_data | output | CMD_W | Offered command word, unchanged from the pushed word |
| cmd_ready | input | 1 | Consumer accepts the offered command |
| repeat_trig | input | 1 | Repeat trigger pulse |
| advance_trig | input | 1 | Advance trigger pulse |
| paused | output | 1 | Sequencer halted after a pause command |
| wr_ptr | output | PW | Write pointer, slot index plus wrap bit |
| rd_ptr | output | PW | Read pointer, slot index plus wrap bit |
| rpt_ptr | output | PW | Start of the protected section |
| rpt_valid | output | 1 | Protected section exists |

## Verification
The bench builds the block with its default eight slots of 32 bits, giving four-bit pointers with one wrap bit. At that size one scenario can push the write pointer past a full wrap while a section is protected. It can then fill the storage so that the flag depends only on the protected slots, and later fill all eight slots behind a stalled consumer with the read pointer already past its first wrap. The same small depth keeps two replays, a release by a held advance and a release by a same-cycle advance within a few hundred cycles.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic {SEQ_RUN = 1'b0, SEQ_HOLD = 1'b1} seq_state_e;

  // distance from tail to head on a ring of 2**pw pointer values
  function automatic int unsigned ring_level(input int unsigned head,
                                             input int unsigned tail,
                                             input int unsigned pw);
    return (head - tail) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/rcs_store.sv
module rcs_store #(
  parameter int DEPTH = 8,
  parameter int CMD_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CMD_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CMD_W-1:0] rd_data
);
  logic [CMD_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/rcs_advlatch.sv
module rcs_advlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_in,
  input  logic consume,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (consume) pending <= 1'b0;
    else if (adv_in)  pending <= 1'b1;
  end
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_fire,
  input  logic          pop_pause,
  input  logic          pop_repeat,
  input  logic          repeat_trig,
  input  logic          adv_eff,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] rpt_ptr,
  output logic          rpt_valid,
  output logic          hold,
  output logic          replay_ev,
  output logic          release_ev
);
  seq_state_e state_q;

  assign hold       = (state_q == SEQ_HOLD);
  assign replay_ev  = hold && repeat_trig && !adv_eff;
  assign release_ev = hold && repeat_trig && adv_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEQ_RUN;
      rd_ptr    <= '0;
      rpt_ptr   <= '0;
      rpt_valid <= 1'b0;
    end else begin
      if (pop_fire) begin
        rd_ptr <= rd_ptr + PW'(1);
        if (pop_repeat) begin
          rpt_ptr   <= rd_ptr;
          rpt_valid <= 1'b1;
        end
        if (pop_pause) state_q <= SEQ_HOLD;
      end
      if (replay_ev) begin
        state_q <= SEQ_RUN;
        if (rpt_valid) rd_ptr <= rpt_ptr;
      end
      if (release_ev) begin
        state_q   <= SEQ_RUN;
        rpt_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpt_cmd_seq.sv
module rpt_cmd_seq
  import rcs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CMD_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int PAUSE_BIT = CMD_W - 1,
  localparam int REPEAT_BIT = CMD_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [CMD_W-1:0] push_data,
  output logic             full,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  input  logic             cmd_ready,
  input  logic             repeat_trig,
  input  logic             advance_trig,
  output logic             paused,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    rpt_ptr,
  output logic             rpt_valid
);
  logic [PW-1:0] base_ptr;
  logic [PW-1:0] level;
  logic          push_fire;
  logic          pop_fire;
  logic          empty;
  logic          adv_pending;
  logic          adv_eff;
  logic          replay_ev;
  logic          release_ev;

  // occupancy counts the protected section when one exists
  assign base_ptr  = rpt_valid ? rpt_ptr : rd_ptr;
  assign level     = PW'(ring_level(32'(wr_ptr), 32'(base_ptr), PW));
  assign full      = (level == PW'(DEPTH));
  assign push_fire = push_valid && !full;
  assign empty     = (rd_ptr == wr_ptr);
  assign cmd_valid = !paused && !empty;
  assign pop_fire  = cmd_valid && cmd_ready;
  assign adv_eff   = adv_pending || advance_trig;

  always_ff @(posedge clk) begin
    if (!rst_n)         wr_ptr <= '0;
    else if (push_fire) wr_ptr <= wr_ptr + PW'(1);
  end

  rcs_store #(.DEPTH(DEPTH), .CMD_W(CMD_W)) store_i (
    .clk     (clk),
    .wr_en   (push_fire),
    .wr_addr (wr_ptr[AW-1:0]),
    .wr_data (push_data),
    .rd_addr (rd_ptr[AW-1:0]),
    .rd_data (cmd_data)
  );

  rcs_advlatch adv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_in  (advance_trig),
    .consume (release_ev),
    .pending (adv_pending)
  );

  rcs_ctrl #(.PW(PW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_fire    (pop_fire),
    .pop_pause   (cmd_data[PAUSE_BIT]),
    .pop_repeat  (cmd_data[REPEAT_BIT]),
    .repeat_trig (repeat_trig),
    .adv_eff     (adv_eff),
    .rd_ptr      (rd_ptr),
    .rpt_ptr     (rpt_ptr),
    .rpt_valid   (rpt_valid),
    .hold        (paused),
    .replay_ev   (replay_ev),
    .release_ev  (release_ev)
  );
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk #(
  parameter int DEPTH = 8,
  parameter int CMD_W = 32,
  parameter int PW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             full,
  input logic [PW-1:0]    wr_ptr,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd_data,
  input logic             paused,
  input logic [PW-1:0]    rd_ptr,
  input logic [PW-1:0]    rpt_ptr,
  input logic             rpt_valid,
  input logic             repeat_trig,
  input logic             advance_trig,
  input logic             adv_pending,
  input logic             pop_fire
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> (wr_ptr == $past(wr_ptr)));

  assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (rd_ptr == $past(rd_ptr) + PW'(1)));

  assert_repeat_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && cmd_data[CMD_W-2]) |=> (rpt_valid && rpt_ptr == $past(rd_ptr)));

  assert_protect_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && (PW'(wr_ptr - rpt_ptr) == PW'(DEPTH))) |-> full);

  assert_pause_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && cmd_data[CMD_W-1]) |=> paused);

  assert_pause_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !cmd_valid);

  assert_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && repeat_trig && !adv_pending && !advance_trig && rpt_valid)
      |=> (!paused && rd_ptr == $past(rpt_ptr)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && repeat_trig && (adv_pending || advance_trig))
      |=> (!paused && !rpt_valid && $stable(rd_ptr)));

  assert_adv_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_trig && !(paused && repeat_trig)) |=> adv_pending);

  assert_idle_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused && repeat_trig && !pop_fire) |=> ($stable(rd_ptr) && !paused));
endmodule

bind rpt_cmd_seq rcs_chk #(.DEPTH(DEPTH), .CMD_W(CMD_W), .PW(PW)) chk_i (.*);

// File: tb/rpt_cmd_seq_tb.sv
module rpt_cmd_seq_tb_top;
  localparam int DEPTH = 8;
  localparam int CMD_W = 32;
  localparam int PW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push_valid = 1'b0;
  logic [CMD_W-1:0] push_data = '0;
  logic             full;
  logic             cmd_valid;
  logic [CMD_W-1:0] cmd_data;
  logic             cmd_ready = 1'b1;
  logic             repeat_trig = 1'b0;
  logic             advance_trig = 1'b0;
  logic             paused;
  logic [PW-1:0]    wr_ptr, rd_ptr, rpt_ptr;
  logic             rpt_valid;

  int               n_tests = 0;
  int               n_fail = 0;
  int               cyc = 0;
  logic [CMD_W-1:0] exp_q[$];
  logic [CMD_W-1:0] exp_w;

  always #4 clk = ~clk;

  rpt_cmd_seq #(.DEPTH(DEPTH), .CMD_W(CMD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .full(full), .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .repeat_trig(repeat_trig), .advance_trig(advance_trig), .paused(paused),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rpt_ptr(rpt_ptr), .rpt_valid(rpt_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares every accepted command with the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R3 unexpected command actual=%h expected=none", cmd_data);
      end else begin
        exp_w = exp_q.pop_front();
        chk("R3 issue order", cmd_data, exp_w);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=below 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_cmd(input logic [31:0] w);
    exp_q.push_back(w);
  endtask

  task automatic push(input logic [31:0] w);
    push_valid = 1'b1;
    push_data  = w;
    step(1);
    push_valid = 1'b0;
  endtask

  task automatic pulse(input logic rep, input logic adv);
    repeat_trig  = rep;
    advance_trig = adv;
    step(1);
    repeat_trig  = 1'b0;
    advance_trig = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step(1);
    step(2);
  endtask

  localparam logic [31:0] W0 = 32'h0000_0010, W1 = 32'h4000_0011;
  localparam logic [31:0] W2 = 32'h0000_0012, W3 = 32'h8000_0013;
  localparam logic [31:0] X4 = 32'h0000_0104, X5 = 32'h8000_0105;
  localparam logic [31:0] X6 = 32'h4000_0106, X7 = 32'h8000_0107;
  localparam logic [31:0] X8 = 32'h0000_0108;

  initial begin
    step(3);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 full", full, 0);
    chk("R1 paused", paused, 0);
    chk("R1 rpt_valid", rpt_valid, 0);
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 rd_ptr", rd_ptr, 0);
    chk("R1 rpt_ptr", rpt_ptr, 0);
    rst_n = 1'b1;
    step(1);

    // first pass: config, repeat-marked, body, pause
    expect_cmd(W0); expect_cmd(W1); expect_cmd(W2); expect_cmd(W3);
    push(W0); push(W1); push(W2); push(W3);
    drain();
    chk("R6 paused after pause cmd", paused, 1);
    chk("R6 silent while paused", cmd_valid, 0);
    chk("R4 rpt_valid", rpt_valid, 1);
    chk("R4 rpt_ptr", rpt_ptr, 1);
    chk("R3 rd_ptr", rd_ptr, 4);

    // fill behind the protected section
    push(X4); push(X5); push(X6); push(X7); push(X8);
    chk("R5 full counts protected slots", full, 1);
    chk("R2 wr_ptr wrapped", wr_ptr, 9);
    push(32'h0000_0FFF);
    chk("R2 dropped push", wr_ptr, 9);
    chk("R6 no issue while paused", cmd_valid, 0);

    // replay without advance
    expect_cmd(W1); expect_cmd(W2); expect_cmd(W3);
    pulse(1'b1, 1'b0);
    chk("R7 rd_ptr reloaded", rd_ptr, 1);
    chk("R7 resumed", paused, 0);
    drain();
    chk("R7 paused again", paused, 1);
    chk("R7 rd_ptr after replay", rd_ptr, 4);

    // two advance pulses held, no effect yet
    pulse(1'b0, 1'b1);
    step(3);
    pulse(1'b0, 1'b1);
    chk("R9 still paused", paused, 1);
    chk("R9 rd_ptr untouched", rd_ptr, 4);
    chk("R9 section kept", rpt_valid, 1);

    // release: continue after pause command
    expect_cmd(X4); expect_cmd(X5);
    pulse(1'b1, 1'b0);
    chk("R8 rpt_valid cleared", rpt_valid, 0);
    chk("R8 space released", full, 0);
    chk("R8 rd_ptr kept", rd_ptr, 4);
    drain();
    chk("R8 paused at X5", paused, 1);

    // pause with no section: trigger just resumes
    expect_cmd(X6); expect_cmd(X7);
    pulse(1'b1, 1'b0);
    chk("R11 resumed", paused, 0);
    drain();
    chk("R4 new rpt_ptr", rpt_ptr, 6);
    chk("R4 rpt_valid again", rpt_valid, 1);
    chk("R11 rd_ptr", rd_ptr, 8);

    // pending must have been consumed: plain replay
    expect_cmd(X6); expect_cmd(X7);
    pulse(1'b1, 1'b0);
    chk("R9 pending cleared so replay", rd_ptr, 6);
    drain();

    // advance in the same cycle as the repeat trigger
    expect_cmd(X8);
    pulse(1'b1, 1'b1);
    chk("R8 same-cycle advance", rpt_valid, 0);
    drain();
    chk("R8 not paused", paused, 0);
    chk("R3 empty", cmd_valid, 0);
    chk("R3 rd_ptr", rd_ptr, 9);

    pulse(1'b1, 1'b0);
    step(1);
    chk("R10 idle trigger rd_ptr", rd_ptr, 9);
    chk("R10 idle trigger paused", paused, 0);

    // backpressure with all eight slots filled
    cmd_ready = 1'b0;
    for (int i = 0; i < 8; i++) push(32'h0000_0200 + 32'(i));
    chk("R2 full at eight", full, 1);
    chk("R2 wr_ptr", wr_ptr, 1);
    push(32'h0000_0EEE);
    chk("R2 push dropped when full", wr_ptr, 1);
    chk("R3 offered", cmd_valid, 1);
    chk("R3 head data", cmd_data, 32'h0000_0200);
    pulse(1'b1, 1'b0);
    chk("R10 busy trigger rd_ptr", rd_ptr, 9);
    chk("R10 busy trigger paused", paused, 0);
    step(3);
    chk("R3 data held", cmd_data, 32'h0000_0200);
    for (int i = 0; i < 8; i++) expect_cmd(32'h0000_0200 + 32'(i));
    cmd_ready = 1'b1;
    drain();
    chk("R3 rd_ptr after wrap", rd_ptr, 1);
    chk("R2 not full", full, 0);
    chk("R3 drained", cmd_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule